// File: doc/BRIEF.md
# Delay-Adaptive Multi-Link Frame Distributor

This block sits on the transmit side of a link-aggregation path. It accepts Ethernet frames as a byte stream with start and end markers, cuts every frame into segments of at most `SEG_MAX` payload bytes, and sends each segment over one of `NLINK` parallel physical links. Each link output is a byte stream with segment start and end markers, ready to be wrapped by a per-link serial framer.

The link for each segment is picked at the moment the segment is complete. The block picks the link with the lowest delay estimate, which is the link's reported queued-byte count plus its latency offset. Links that have stalled are left out. So that no link carries a whole multi-segment frame, the link used by the previous segment of the same frame is skipped when another link can take the segment.

Every segment starts with a three-byte header. The header carries the frame sequence number and the position of the segment within the frame, so the far end can line the streams up again and rebuild frames in their original order.

Top module: `mld_distributor`

## Requirements
- R1: After reset no link output is valid, `in_ready` is high and the frame sequence number is 0.
- R2: Every segment is sent on one link as three header bytes followed by its payload. Byte 0 is sequence[15:8], byte 1 is sequence[7:0], and byte 2 holds the last-segment flag in bit 7 and the segment index in bits 6:0. `lk_sop` marks the first header byte and `lk_eop` marks the final byte of the segment.
- R3: Payload bytes keep their input order. Every segment carries exactly `SEG_MAX` payload bytes except the final segment of a frame, which carries the 1 to `SEG_MAX` bytes that remain. A frame whose length is an exact multiple of `SEG_MAX` therefore has no empty segment.
- R4: Each segment goes to the eligible link with the smallest `lk_backlog + lk_offset`. The sum is computed without overflow. Among equal sums the lowest link index wins.
- R5: Within one frame, a segment never goes to the link that carried the previous segment while any other non-stalled link exists.
- R6: The sequence number increases by one after the final segment of each frame, wrapping modulo 2^16. The segment index is 0 for the first segment of a frame and rises by one per segment.
- R7: A link whose `lk_ready` has been low for `stall_limit` consecutive cycles is not chosen for new segments. It becomes eligible again one cycle after its `lk_ready` returns high. A `stall_limit` of 0 disables this exclusion.
- R8: At most one link output is valid in any cycle.
- R9: While a link output is valid and its `lk_ready` is low, the output stays valid and its data does not change.
- R10: `in_ready` is low for as long as any segment is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with `in_valid` |
| in_data | input | 8 | Input frame byte |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Final byte of a frame |
| stall_limit | input | TW | Consecutive not-ready cycles before a link is excluded (0 = never) |
| lk_backlog | input | NLINK x BW | Queued bytes reported by each link |
| lk_offset | input | NLINK x BW | Fixed latency offset of each link |
| lk_valid | output | NLINK | Per-link byte valid |
| lk_ready | input | NLINK | Per-link byte ready |
| lk_data | output | NLINK x 8 | Per-link byte |
| lk_sop | output | NLINK | First byte of a segment on that link |
| lk_eop | output | NLINK | Final byte of a segment on that link |

## Verification
The bench accepts the final input byte of a segment at clock edge k. The link choice is made in the cycle after edge k, and the first header byte appears on the chosen link right after edge k+1. Each further header or payload byte follows one cycle after the previous byte is accepted. The bench does not count edges to predict when a byte appears. It queues every expected header and payload byte together with its link, and a monitor pops that queue each time a valid-and-ready handshake is seen. All comparisons happen on the falling clock edge, so they read settled values. Backlog, offset, ready and stall settings are changed only after the queue has drained, so the selection cycle always sees the values the bench used for its own prediction.

// File: rtl/mld_pkg.sv
package mld_pkg;
  localparam int HDR_BYTES = 3;
  localparam int SEQ_W     = 16;
  localparam int IDX_W     = 7;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_PICK = 2'd1,
    ST_SEND = 2'd2
  } seg_state_e;
endpackage

// File: rtl/mld_health.sv
module mld_health #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic [TW-1:0] limit,
  output logic          dead
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (ready)                cnt_d = '0;
    else if (cnt_q >= limit)  cnt_d = limit;
    else                      cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign dead = (limit != '0) && (cnt_q >= limit);
endmodule

// File: rtl/mld_select.sv
module mld_select #(
  parameter int NLINK = 3,
  parameter int BW    = 8,
  parameter int IW    = 2
) (
  input  logic [NLINK-1:0][BW-1:0] backlog,
  input  logic [NLINK-1:0][BW-1:0] offset,
  input  logic [NLINK-1:0]         elig,
  output logic                     any,
  output logic [IW-1:0]            pick
);
  logic [BW:0] best_c;
  logic [BW:0] cost_v;

  always_comb begin
    any    = 1'b0;
    pick   = '0;
    best_c = '0;
    cost_v = '0;
    for (int i = 0; i < NLINK; i++) begin
      cost_v = {1'b0, backlog[i]} + {1'b0, offset[i]};
      if (elig[i] && (!any || (cost_v < best_c))) begin
        any    = 1'b1;
        best_c = cost_v;
        pick   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mld_segmenter.sv
module mld_segmenter
  import mld_pkg::*;
#(
  parameter int NLINK   = 3,
  parameter int SEG_MAX = 8,
  parameter int IW      = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_data,
  input  logic                    in_sop,
  input  logic                    in_eop,
  output logic                    pick_req,
  input  logic                    pick_any,
  input  logic [IW-1:0]           pick_idx,
  output logic                    prev_valid,
  output logic [IW-1:0]           prev_idx,
  output logic [NLINK-1:0]        lk_valid,
  input  logic [NLINK-1:0]        lk_ready,
  output logic [NLINK-1:0][7:0]   lk_data,
  output logic [NLINK-1:0]        lk_sop,
  output logic [NLINK-1:0]        lk_eop,
  output logic [SEQ_W-1:0]        seq,
  output logic                    frame_done
);
  localparam int CW = $clog2(SEG_MAX + 1);
  localparam int PW = $clog2(SEG_MAX + HDR_BYTES);

  seg_state_e                 state_q, state_d;
  logic [SEG_MAX-1:0][7:0]    buf_q, buf_d;
  logic [CW-1:0]              cnt_q, cnt_d;
  logic [CW-1:0]              len_q, len_d;
  logic                       last_q, last_d;
  logic [PW-1:0]              pos_q, pos_d;
  logic [IW-1:0]              sel_q, sel_d;
  logic [SEQ_W-1:0]           seq_q, seq_d;
  logic [IDX_W-1:0]           idx_q, idx_d;
  logic                       pv_q, pv_d;
  logic [IW-1:0]              pidx_q, pidx_d;

  logic                       accept;
  logic                       sel_ready;
  logic                       byte_done;
  logic                       at_end;
  logic [PW-1:0]              end_pos;
  logic [7:0]                 cur_byte;

  assign in_ready  = (state_q == ST_FILL);
  assign accept    = in_ready && in_valid;
  assign pick_req  = (state_q == ST_PICK);
  assign sel_ready = lk_ready[sel_q];
  assign byte_done = (state_q == ST_SEND) && sel_ready;
  assign end_pos   = PW'(len_q) + PW'(HDR_BYTES - 1);
  assign at_end    = (pos_q == end_pos);

  always_comb begin
    cur_byte = 8'h00;
    if (pos_q == PW'(0))      cur_byte = seq_q[15:8];
    else if (pos_q == PW'(1)) cur_byte = seq_q[7:0];
    else if (pos_q == PW'(2)) cur_byte = {last_q, idx_q};
    else begin
      for (int j = 0; j < SEG_MAX; j++) begin
        if (pos_q == PW'(j + HDR_BYTES)) cur_byte = buf_q[j];
      end
    end
  end

  generate
    for (genvar g = 0; g < NLINK; g++) begin : g_out
      logic on_link;
      assign on_link    = (state_q == ST_SEND) && (sel_q == IW'(g));
      assign lk_valid[g] = on_link;
      assign lk_data[g]  = on_link ? cur_byte : 8'h00;
      assign lk_sop[g]   = on_link && (pos_q == '0);
      assign lk_eop[g]   = on_link && at_end;
    end
  endgenerate

  always_comb begin
    state_d    = state_q;
    buf_d      = buf_q;
    cnt_d      = cnt_q;
    len_d      = len_q;
    last_d     = last_q;
    pos_d      = pos_q;
    sel_d      = sel_q;
    seq_d      = seq_q;
    idx_d      = idx_q;
    pv_d       = pv_q;
    pidx_d     = pidx_q;
    frame_done = 1'b0;
    unique case (state_q)
      ST_FILL: begin
        if (accept) begin
          for (int j = 0; j < SEG_MAX; j++) begin
            if (cnt_q == CW'(j)) buf_d[j] = in_data;
          end
          if (in_sop && (cnt_q == '0)) begin
            idx_d = '0;
            pv_d  = 1'b0;
          end
          if (in_eop || (cnt_q == CW'(SEG_MAX - 1))) begin
            len_d   = cnt_q + CW'(1);
            last_d  = in_eop;
            cnt_d   = '0;
            state_d = ST_PICK;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      ST_PICK: begin
        if (pick_any) begin
          sel_d   = pick_idx;
          pos_d   = '0;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (byte_done) begin
          if (at_end) begin
            state_d = ST_FILL;
            if (last_q) begin
              seq_d      = seq_q + SEQ_W'(1);
              idx_d      = '0;
              pv_d       = 1'b0;
              frame_done = 1'b1;
            end else begin
              idx_d  = idx_q + IDX_W'(1);
              pv_d   = 1'b1;
              pidx_d = sel_q;
            end
          end else begin
            pos_d = pos_q + PW'(1);
          end
        end
      end
      default: state_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      buf_q   <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      last_q  <= 1'b0;
      pos_q   <= '0;
      sel_q   <= '0;
      seq_q   <= '0;
      idx_q   <= '0;
      pv_q    <= 1'b0;
      pidx_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) buf_q <= buf_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      last_q  <= last_d;
      pos_q   <= pos_d;
      sel_q   <= sel_d;
      seq_q   <= seq_d;
      idx_q   <= idx_d;
      pv_q    <= pv_d;
      pidx_q  <= pidx_d;
    end
  end

  assign prev_valid = pv_q;
  assign prev_idx   = pidx_q;
  assign seq        = seq_q;
endmodule

// File: rtl/mld_distributor.sv
module mld_distributor
  import mld_pkg::*;
#(
  parameter int NLINK   = 3,
  parameter int SEG_MAX = 8,
  parameter int BW      = 8,
  parameter int TW      = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_data,
  input  logic                    in_sop,
  input  logic                    in_eop,
  input  logic [TW-1:0]           stall_limit,
  input  logic [NLINK-1:0][BW-1:0] lk_backlog,
  input  logic [NLINK-1:0][BW-1:0] lk_offset,
  output logic [NLINK-1:0]        lk_valid,
  input  logic [NLINK-1:0]        lk_ready,
  output logic [NLINK-1:0][7:0]   lk_data,
  output logic [NLINK-1:0]        lk_sop,
  output logic [NLINK-1:0]        lk_eop
);
  localparam int IW = (NLINK > 1) ? $clog2(NLINK) : 1;

  logic [NLINK-1:0] lk_dead;
  logic [NLINK-1:0] alive;
  logic [NLINK-1:0] excl;
  logic [NLINK-1:0] elig;
  logic             pick_req;
  logic             pick_any_raw;
  logic             pick_any;
  logic [IW-1:0]    pick_idx;
  logic             prev_valid;
  logic [IW-1:0]    prev_idx;
  logic [SEQ_W-1:0] seq_q;
  logic             frame_done;

  generate
    for (genvar g = 0; g < NLINK; g++) begin : g_health
      mld_health #(.TW(TW)) u_health (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (lk_ready[g]),
        .limit (stall_limit),
        .dead  (lk_dead[g])
      );
      assign excl[g] = prev_valid && (prev_idx == IW'(g));
    end
  endgenerate

  assign alive = ~lk_dead;
  assign elig  = ((alive & ~excl) != '0) ? (alive & ~excl) : alive;

  mld_select #(.NLINK(NLINK), .BW(BW), .IW(IW)) u_select (
    .backlog (lk_backlog),
    .offset  (lk_offset),
    .elig    (elig),
    .any     (pick_any_raw),
    .pick    (pick_idx)
  );

  assign pick_any = pick_any_raw && pick_req;

  mld_segmenter #(.NLINK(NLINK), .SEG_MAX(SEG_MAX), .IW(IW)) u_seg (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_sop     (in_sop),
    .in_eop     (in_eop),
    .pick_req   (pick_req),
    .pick_any   (pick_any),
    .pick_idx   (pick_idx),
    .prev_valid (prev_valid),
    .prev_idx   (prev_idx),
    .lk_valid   (lk_valid),
    .lk_ready   (lk_ready),
    .lk_data    (lk_data),
    .lk_sop     (lk_sop),
    .lk_eop     (lk_eop),
    .seq        (seq_q),
    .frame_done (frame_done)
  );
endmodule

// File: rtl/mld_distributor_chk.sv
module mld_distributor_chk #(
  parameter int NLINK = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_ready,
  input logic [NLINK-1:0]      lk_valid,
  input logic [NLINK-1:0]      lk_ready,
  input logic [NLINK-1:0][7:0] lk_data,
  input logic [NLINK-1:0]      lk_dead,
  input logic [15:0]           seq_q,
  input logic                  frame_done
);
  a_r8_one_link: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_valid));

  a_r10_input_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid != '0) |-> !in_ready);

  a_r6_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (seq_q == $past(seq_q) + 16'd1));

  a_r6_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(seq_q));

  generate
    for (genvar g = 0; g < NLINK; g++) begin : g_link
      a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid[g] && !lk_ready[g]) |=> (lk_valid[g] && $stable(lk_data[g])));

      a_r7_skip_dead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lk_valid[g]) |-> !$past(lk_dead[g]));
    end
  endgenerate
endmodule

bind mld_distributor mld_distributor_chk #(.NLINK(NLINK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .lk_valid   (lk_valid),
  .lk_ready   (lk_ready),
  .lk_data    (lk_data),
  .lk_dead    (lk_dead),
  .seq_q      (seq_q),
  .frame_done (frame_done)
);

// File: tb/tb_mld_distributor.sv
`timescale 1ns/1ps
module tb_mld_distributor;
  localparam int NLINK   = 3;
  localparam int SEG_MAX = 8;
  localparam int BW      = 8;
  localparam int TW      = 8;

  logic                     clk;
  logic                     rst_n;
  logic                     in_valid;
  logic                     in_ready;
  logic [7:0]               in_data;
  logic                     in_sop;
  logic                     in_eop;
  logic [TW-1:0]            stall_limit;
  logic [NLINK-1:0][BW-1:0] lk_backlog;
  logic [NLINK-1:0][BW-1:0] lk_offset;
  logic [NLINK-1:0]         lk_valid;
  logic [NLINK-1:0]         lk_ready;
  logic [NLINK-1:0][7:0]    lk_data;
  logic [NLINK-1:0]         lk_sop;
  logic [NLINK-1:0]         lk_eop;

  mld_distributor #(.NLINK(NLINK), .SEG_MAX(SEG_MAX), .BW(BW), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .stall_limit(stall_limit), .lk_backlog(lk_backlog), .lk_offset(lk_offset),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_data(lk_data),
    .lk_sop(lk_sop), .lk_eop(lk_eop)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string tag = "R2";
  logic [11:0] exp_q[$];
  logic [15:0] seq_m = 16'd0;
  logic [NLINK-1:0] man_ready = '1;
  logic [NLINK-1:0] dead_m = '0;
  logic bp_en = 1'b0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bp_en) begin
      for (int i = 0; i < NLINK; i++) lk_ready[i] <= ((cyc % 3) != i);
    end else begin
      lk_ready <= man_ready;
    end
  end

  logic [NLINK-1:0]      hold_v = '0;
  logic [NLINK-1:0][7:0] hold_d;

  always @(negedge clk) begin
    if (rst_n) begin
      if (lk_valid != '0) chk($countones(lk_valid) <= 1, "R8", lk_valid, 0);
      if (lk_valid != '0) chk(!in_ready, "R10", in_ready, 0);
      for (int i = 0; i < NLINK; i++) begin
        if (hold_v[i]) begin
          chk(lk_valid[i] && (lk_data[i] == hold_d[i]), "R9", lk_data[i], hold_d[i]);
        end
        hold_v[i] = lk_valid[i] && !lk_ready[i];
        hold_d[i] = lk_data[i];
        if (lk_valid[i] && lk_ready[i]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, tag, i, 'hfff);
          end else begin
            logic [11:0] e;
            logic [11:0] a;
            e = exp_q.pop_front();
            a = {2'(i), lk_sop[i], lk_eop[i], lk_data[i]};
            chk(a == e, tag, a, e);
          end
        end
      end
    end
  end

  function automatic int pick_model(input int prev, input bit pv);
    logic [NLINK-1:0] alive;
    logic [NLINK-1:0] el;
    int best;
    int bc;
    alive = ~dead_m;
    el = alive;
    if (pv && ((alive & ~(NLINK'(1) << prev)) != '0)) el = alive & ~(NLINK'(1) << prev);
    best = -1;
    bc = 0;
    for (int i = 0; i < NLINK; i++) begin
      int c;
      c = int'(lk_backlog[i]) + int'(lk_offset[i]);
      if (el[i] && (best < 0 || c < bc)) begin
        best = i;
        bc = c;
      end
    end
    return best;
  endfunction

  task automatic send_frame(input int len, input int seed);
    int nseg;
    int prev;
    bit pv;
    nseg = (len + SEG_MAX - 1) / SEG_MAX;
    prev = 0;
    pv = 1'b0;
    for (int s = 0; s < nseg; s++) begin
      int lk;
      int sl;
      bit last;
      last = (s == nseg - 1);
      sl = last ? (len - s * SEG_MAX) : SEG_MAX;
      lk = pick_model(prev, pv);
      exp_q.push_back({2'(lk), 1'b1, 1'b0, seq_m[15:8]});
      exp_q.push_back({2'(lk), 1'b0, 1'b0, seq_m[7:0]});
      exp_q.push_back({2'(lk), 1'b0, 1'b0, last, 7'(s)});
      for (int k = 0; k < sl; k++) begin
        exp_q.push_back({2'(lk), 1'b0, (k == sl - 1), 8'((seed + (s * SEG_MAX + k) * 7) & 255)});
      end
      prev = lk;
      pv = 1'b1;
    end
    seq_m = seq_m + 16'd1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'((seed + k * 7) & 255);
      in_sop   = (k == 0);
      in_eop   = (k == len - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sop = 1'b0;
    in_eop = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cost(input int b0, input int b1, input int b2,
                          input int o0, input int o1, input int o2);
    lk_backlog[0] = BW'(b0); lk_backlog[1] = BW'(b1); lk_backlog[2] = BW'(b2);
    lk_offset[0]  = BW'(o0); lk_offset[1]  = BW'(o1); lk_offset[2]  = BW'(o2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = 8'h00;
    in_sop = 1'b0;
    in_eop = 1'b0;
    stall_limit = TW'(20);
    set_cost(4, 4, 4, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs idle, input open
    chk(lk_valid == '0, "R1", lk_valid, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);

    // R2: single short frame, header layout
    tag = "R2";
    send_frame(3, 16);
    drain();

    // R3: exact multiple, short tail, long frame
    tag = "R3";
    send_frame(SEG_MAX, 40);
    drain();
    send_frame(2 * SEG_MAX, 3);
    drain();
    send_frame(21, 99);
    drain();
    send_frame(1, 200);
    drain();

    // R4: lowest backlog+offset wins; ties go to lowest index
    tag = "R4";
    set_cost(9, 3, 7, 0, 2, 0);
    send_frame(20, 5);
    drain();
    set_cost(200, 100, 255, 100, 200, 1);
    send_frame(5, 77);
    drain();
    set_cost(6, 6, 6, 0, 0, 0);
    send_frame(4, 11);
    drain();

    // R5: consecutive segments avoid the previous link
    tag = "R5";
    set_cost(1, 2, 50, 0, 0, 0);
    send_frame(4 * SEG_MAX, 60);
    drain();

    // R6: sequence and index across frames
    tag = "R6";
    for (int f = 0; f < 5; f++) begin
      send_frame(9 + f, f * 13);
      drain();
    end

    // R7: stalled link excluded, then restored
    tag = "R7";
    stall_limit = TW'(4);
    set_cost(0, 5, 6, 0, 0, 0);
    @(negedge clk);
    man_ready = 3'b110;
    repeat (8) @(negedge clk);
    dead_m = 3'b001;
    send_frame(2 * SEG_MAX, 31);
    drain();
    man_ready = 3'b111;
    repeat (3) @(negedge clk);
    dead_m = 3'b000;
    send_frame(SEG_MAX + 2, 45);
    drain();
    stall_limit = TW'(0);
    man_ready = 3'b110;
    repeat (8) @(negedge clk);
    send_frame(3, 8);
    man_ready = 3'b111;
    drain();

    // R9: backpressure on links
    tag = "R9";
    stall_limit = TW'(20);
    set_cost(2, 2, 2, 0, 1, 2);
    bp_en = 1'b1;
    send_frame(19, 123);
    drain();
    send_frame(6, 9);
    drain();
    bp_en = 1'b0;
    repeat (3) @(negedge clk);

    chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
    chk(lk_valid == '0, "R10", lk_valid, 0);
    chk(in_ready == 1'b1, "R10", in_ready, 1);
    report();
  end
endmodule